// File: doc/BRIEF.md
# Processor Mailbox Message Unit

This block carries short 32-bit messages between a local compute element and a control processor. It holds three independent queues. The plain outbound queue and the interrupting outbound queue each hold one message, written by the local element and drained by the control processor. The inbound queue holds four messages, written by the control processor and drained by the local element.

The local element uses a channel-style valid/ready handshake on each queue. A writer that finds its outbound slot occupied is held off. A reader that finds the inbound queue empty waits. The control processor uses a single-cycle register port with a 2-bit address. Read data is combinational from the address. A read strobe drains the addressed outbound slot at the clock edge, and a write strobe pushes into the inbound queue. A status word reports how full the queues are.

When the inbound queue is full, a further control write replaces the newest entry instead of being refused. The interrupting outbound slot drives a level interrupt for as long as it holds a message.

Top module: `mbox_unit`

## Requirements
- R1: After reset all three queues are empty, `irq_o` is low, both local write `ready` outputs are high and `lr_valid` is low.
- R2: A local write to the empty plain outbound slot is accepted at the clock edge. A control read at address 0 returns that message, and the strobed edge empties the slot.
- R3: While the plain outbound slot is full, `lo_wr_ready` stays low and the stored message is unchanged. `lo_wr_ready` returns high in the cycle after the control read that drains the slot.
- R4: The interrupting outbound slot, read at address 1 through `li_wr_*`, accepts, holds, stalls and drains exactly like the plain slot.
- R5: `irq_o` rises in the cycle after a write into the interrupting slot is accepted. It stays high while that slot is full and falls in the cycle after the control read at address 1.
- R6: Control writes at address 2 enter the inbound queue, which holds up to 4 messages. The local side receives them oldest first on `lr_data` whenever `lr_valid` and `lr_ready` are both high at an edge.
- R7: A control write at address 2 while 4 messages are held and no local read happens replaces the newest message. The count stays at 4 and the three older messages are unchanged.
- R8: A control write and a local read in the same cycle on a full inbound queue remove the oldest message and append the new one. The count stays at 4 and nothing is overwritten.
- R9: `lr_valid` is low whenever the inbound queue is empty, so the local reader waits.
- R10: A control read at address 3 returns the status word. Bits [2:0] give the number of free inbound slots (0 to 4), bit 8 gives the plain outbound count and bit 9 gives the interrupting outbound count. All other bits are zero.
- R11: A control read of an empty outbound slot returns zero and changes nothing. Control writes at addresses 0, 1 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lo_wr_valid | input | 1 | Local write request, plain outbound |
| lo_wr_ready | output | 1 | Plain outbound slot can accept |
| lo_wr_data | input | 32 | Plain outbound message |
| li_wr_valid | input | 1 | Local write request, interrupting outbound |
| li_wr_ready | output | 1 | Interrupting slot can accept |
| li_wr_data | input | 32 | Interrupting outbound message |
| lr_valid | output | 1 | Inbound message available |
| lr_ready | input | 1 | Local reader takes the message |
| lr_data | output | 32 | Oldest inbound message |
| cp_addr | input | 2 | Control register address |
| cp_wr_en | input | 1 | Control write strobe |
| cp_wdata | input | 32 | Control write data |
| cp_rd_en | input | 1 | Control read strobe (drains outbound) |
| cp_rdata | output | 32 | Control read data |
| irq_o | output | 1 | Level interrupt to control processor |

## Verification
Two events can land on the same edge here. A control write and a local read can meet on a full inbound queue, and a control drain can meet a local writer that is held off on a full outbound slot. The bench fills the inbound queue to four, then raises `cp_wr_en` and `lr_ready` together. It expects the oldest message out, the count still four, and the new message last in the following reads, rather than an overwrite. For the stalled writer it holds `lo_wr_valid` through the draining read. It expects the old message on the bus, `ready` high only on the next cycle, and the waiting message accepted one edge later.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

   localparam int unsigned CP_ADDR_W    = 2;
   localparam int unsigned STAT_OUT_BIT = 8;
   localparam int unsigned STAT_IRQ_BIT = 9;

   typedef enum logic [CP_ADDR_W-1:0] {
      REG_OUT      = 2'd0,
      REG_OUT_IRQ  = 2'd1,
      REG_IN       = 2'd2,
      REG_STAT     = 2'd3
   } mbox_reg_e;

endpackage

// File: rtl/mbox_out_slot.sv
module mbox_out_slot #(
   parameter int unsigned W      = 32,
   parameter bit          IRQ_EN = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_valid,
   output logic         wr_ready,
   input  logic [W-1:0] wr_data,
   input  logic         rd_pop,
   output logic         full,
   output logic [W-1:0] data,
   output logic         irq
);

   if (W < 1) begin : g_bad_width
      $error("mbox_out_slot: W must be at least 1");
   end

   logic         full_q;
   logic [W-1:0] data_q;
   logic         wr_fire;

   assign wr_fire  = wr_valid && !full_q;
   assign wr_ready = !full_q;
   assign full     = full_q;
   assign data     = data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         data_q <= '0;
      end else if (wr_fire) begin
         full_q <= 1'b1;
         data_q <= wr_data;
      end else if (rd_pop && full_q) begin
         full_q <= 1'b0;
      end
   end

   if (IRQ_EN) begin : g_irq
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            irq_q <= 1'b0;
         end else if (wr_fire) begin
            irq_q <= 1'b1;
         end else if (rd_pop) begin
            irq_q <= 1'b0;
         end
      end
      assign irq = irq_q;

      assert_irq_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
         irq_q == full_q);
      assert_irq_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(irq_q) |-> $past(wr_valid));
   end else begin : g_no_irq
      assign irq = 1'b0;
   end

   assert_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (full_q && !rd_pop) |=> (full_q && $stable(data_q)));
   assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (full_q && rd_pop) |=> wr_ready);

endmodule

// File: rtl/mbox_in_fifo.sv
module mbox_in_fifo #(
   parameter int unsigned W     = 32,
   parameter int unsigned DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [W-1:0]      push_data,
   input  logic              pop,
   output logic [W-1:0]      head,
   output logic              nonempty,
   output logic [$clog2(DEPTH+1)-1:0] free
);

   localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("mbox_in_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] rd_ptr;
   logic [CW-1:0] cnt;
   logic [PW-1:0] wr_idx;
   logic          is_full;

   assign is_full  = (cnt == CW'(DEPTH));
   assign head     = mem[rd_ptr];
   assign nonempty = (cnt != '0);
   assign free     = CW'(DEPTH) - cnt;

   always_comb begin
      if (is_full && !pop) begin
         wr_idx = rd_ptr + PW'(DEPTH - 1);
      end else begin
         wr_idx = rd_ptr + cnt[PW-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (push) begin
         mem[wr_idx] <= push_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (pop) begin
            rd_ptr <= rd_ptr + PW'(1);
         end
         if (push && !pop && !is_full) begin
            cnt <= cnt + CW'(1);
         end else if (pop && !push) begin
            cnt <= cnt - CW'(1);
         end
      end
   end

   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));
   assert_overwrite_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (is_full && push && !pop) |=> (is_full && $stable(rd_ptr)));
   assert_swap_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (is_full && push && pop) |=> is_full);
   assert_pop_nonempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (cnt != '0));

endmodule

// File: rtl/mbox_unit.sv
module mbox_unit
   import mbox_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned IN_DEPTH = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 lo_wr_valid,
   output logic                 lo_wr_ready,
   input  logic [DATA_W-1:0]    lo_wr_data,
   input  logic                 li_wr_valid,
   output logic                 li_wr_ready,
   input  logic [DATA_W-1:0]    li_wr_data,
   output logic                 lr_valid,
   input  logic                 lr_ready,
   output logic [DATA_W-1:0]    lr_data,
   input  logic [CP_ADDR_W-1:0] cp_addr,
   input  logic                 cp_wr_en,
   input  logic [DATA_W-1:0]    cp_wdata,
   input  logic                 cp_rd_en,
   output logic [DATA_W-1:0]    cp_rdata,
   output logic                 irq_o
);

   localparam int unsigned FREE_W = $clog2(IN_DEPTH + 1);

   if (DATA_W <= STAT_IRQ_BIT) begin : g_bad_data_w
      $error("mbox_unit: DATA_W too narrow for the status word");
   end
   if (FREE_W > STAT_OUT_BIT) begin : g_bad_free_w
      $error("mbox_unit: free count field overlaps outbound bits");
   end

   logic              out_full, irq_full;
   logic [DATA_W-1:0] out_data, irq_data;
   logic              out_pop, irq_pop;
   logic              unused_irq_plain;
   logic              in_push, in_pop;
   logic [FREE_W-1:0] in_free;
   logic [DATA_W-1:0] status;

   assign out_pop = cp_rd_en && (cp_addr == REG_OUT);
   assign irq_pop = cp_rd_en && (cp_addr == REG_OUT_IRQ);
   assign in_push = cp_wr_en && (cp_addr == REG_IN);
   assign in_pop  = lr_valid && lr_ready;

   mbox_out_slot #(.W(DATA_W), .IRQ_EN(1'b0)) i_out_plain (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_valid (lo_wr_valid),
      .wr_ready (lo_wr_ready),
      .wr_data  (lo_wr_data),
      .rd_pop   (out_pop),
      .full     (out_full),
      .data     (out_data),
      .irq      (unused_irq_plain)
   );

   mbox_out_slot #(.W(DATA_W), .IRQ_EN(1'b1)) i_out_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_valid (li_wr_valid),
      .wr_ready (li_wr_ready),
      .wr_data  (li_wr_data),
      .rd_pop   (irq_pop),
      .full     (irq_full),
      .data     (irq_data),
      .irq      (irq_o)
   );

   mbox_in_fifo #(.W(DATA_W), .DEPTH(IN_DEPTH)) i_in_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (in_push),
      .push_data (cp_wdata),
      .pop       (in_pop),
      .head      (lr_data),
      .nonempty  (lr_valid),
      .free      (in_free)
   );

   always_comb begin
      status = '0;
      status[FREE_W-1:0]  = in_free;
      status[STAT_OUT_BIT] = out_full;
      status[STAT_IRQ_BIT] = irq_full;
   end

   always_comb begin
      cp_rdata = '0;
      case (mbox_reg_e'(cp_addr))
         REG_OUT:     if (out_full) cp_rdata = out_data;
         REG_OUT_IRQ: if (irq_full) cp_rdata = irq_data;
         REG_STAT:    cp_rdata = status;
         default:     cp_rdata = '0;
      endcase
   end

   assert_empty_read_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_rd_en && cp_addr == REG_OUT && !out_full) |-> (cp_rdata == '0));
   assert_empty_read_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_rd_en && cp_addr == REG_OUT && !out_full && !lo_wr_valid) |=> !out_full);
   assert_irq_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pop && irq_o) |=> !irq_o);

endmodule

// File: tb/test_mbox_unit.sv
module test_mbox_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lo_wr_valid = 1'b0, li_wr_valid = 1'b0, lr_ready = 1'b0;
   logic [31:0] lo_wr_data = '0, li_wr_data = '0, cp_wdata = '0;
   logic        lo_wr_ready, li_wr_ready, lr_valid, irq_o;
   logic [31:0] lr_data, cp_rdata;
   logic [1:0]  cp_addr = '0;
   logic        cp_wr_en = 1'b0, cp_rd_en = 1'b0;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   mbox_unit i_mbox_unit (
      .clk(clk), .rst_n(rst_n),
      .lo_wr_valid(lo_wr_valid), .lo_wr_ready(lo_wr_ready), .lo_wr_data(lo_wr_data),
      .li_wr_valid(li_wr_valid), .li_wr_ready(li_wr_ready), .li_wr_data(li_wr_data),
      .lr_valid(lr_valid), .lr_ready(lr_ready), .lr_data(lr_data),
      .cp_addr(cp_addr), .cp_wr_en(cp_wr_en), .cp_wdata(cp_wdata),
      .cp_rd_en(cp_rd_en), .cp_rdata(cp_rdata), .irq_o(irq_o)
   );

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic status_is(input string req, input logic [31:0] exp);
      cp_addr = 2'd3;
      #1;
      chk(req, cp_rdata, exp);
   endtask

   task automatic cp_push(input logic [31:0] d);
      cp_addr = 2'd2; cp_wdata = d; cp_wr_en = 1'b1;
      step();
      cp_wr_en = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 irq", {31'd0, irq_o}, 32'd0);
      chk("R1 lo ready", {31'd0, lo_wr_ready}, 32'd1);
      chk("R1 li ready", {31'd0, li_wr_ready}, 32'd1);
      chk("R9 lr_valid empty", {31'd0, lr_valid}, 32'd0);
      status_is("R10 reset status", 32'h0000_0004);
   endtask

   task automatic t_plain();
      lo_wr_valid = 1'b1; lo_wr_data = 32'hA5A5_0001;
      step();
      lo_wr_data = 32'hB0B0_0002;
      chk("R3 ready low when full", {31'd0, lo_wr_ready}, 32'd0);
      status_is("R10 out count", 32'h0000_0104);
      for (int i = 0; i < 3; i++) begin
         step();
         chk("R3 still stalled", {31'd0, lo_wr_ready}, 32'd0);
      end
      cp_addr = 2'd0; cp_rd_en = 1'b1;
      #1;
      chk("R2 read data", cp_rdata, 32'hA5A5_0001);
      chk("R3 ready low in drain cycle", {31'd0, lo_wr_ready}, 32'd0);
      step();
      cp_rd_en = 1'b0;
      chk("R3 ready after drain", {31'd0, lo_wr_ready}, 32'd1);
      step();
      lo_wr_valid = 1'b0;
      cp_addr = 2'd0; cp_rd_en = 1'b1;
      #1;
      chk("R3 waiting message taken", cp_rdata, 32'hB0B0_0002);
      step();
      cp_rd_en = 1'b0;
      status_is("R2 slot emptied", 32'h0000_0004);
   endtask

   task automatic t_irq();
      li_wr_valid = 1'b1; li_wr_data = 32'hC0DE_0003;
      step();
      li_wr_valid = 1'b0;
      chk("R5 irq up", {31'd0, irq_o}, 32'd1);
      chk("R4 li ready low", {31'd0, li_wr_ready}, 32'd0);
      status_is("R10 irq count", 32'h0000_0204);
      step(); step();
      chk("R5 irq held", {31'd0, irq_o}, 32'd1);
      cp_addr = 2'd1; cp_rd_en = 1'b1;
      #1;
      chk("R4 irq slot data", cp_rdata, 32'hC0DE_0003);
      step();
      cp_rd_en = 1'b0;
      chk("R5 irq down", {31'd0, irq_o}, 32'd0);
      chk("R4 li ready back", {31'd0, li_wr_ready}, 32'd1);
   endtask

   task automatic t_empty_read();
      cp_addr = 2'd0; cp_rd_en = 1'b1;
      #1;
      chk("R11 empty read zero", cp_rdata, 32'd0);
      step();
      cp_addr = 2'd1;
      #1;
      chk("R11 empty irq read zero", cp_rdata, 32'd0);
      step();
      cp_rd_en = 1'b0;
      chk("R11 irq unchanged", {31'd0, irq_o}, 32'd0);
      for (int a = 0; a < 4; a++) begin
         if (a == 2) continue;
         cp_addr = 2'(a); cp_wdata = 32'hDEAD_BEEF; cp_wr_en = 1'b1;
         step();
      end
      cp_wr_en = 1'b0;
      chk("R11 writes ignored lr_valid", {31'd0, lr_valid}, 32'd0);
      status_is("R11 status unchanged", 32'h0000_0004);
   endtask

   task automatic pop_expect(input string req, input logic [31:0] exp);
      lr_ready = 1'b1;
      #1;
      chk(req, lr_data, exp);
      chk({req, " valid"}, {31'd0, lr_valid}, 32'd1);
      step();
      lr_ready = 1'b0;
   endtask

   task automatic t_inbound();
      for (int i = 0; i < 4; i++) cp_push(32'h1000_0000 + 32'(i));
      status_is("R6 queue full free=0", 32'h0000_0000);
      cp_push(32'h1000_00FF);
      status_is("R7 still full after overwrite", 32'h0000_0000);
      pop_expect("R6 oldest first", 32'h1000_0000);
      pop_expect("R7 second kept", 32'h1000_0001);
      pop_expect("R7 third kept", 32'h1000_0002);
      pop_expect("R7 newest replaced", 32'h1000_00FF);
      chk("R9 empty after drain", {31'd0, lr_valid}, 32'd0);
   endtask

   task automatic t_concurrent();
      for (int i = 0; i < 4; i++) cp_push(32'h2000_0000 + 32'(i));
      cp_addr = 2'd2; cp_wdata = 32'h2000_0044; cp_wr_en = 1'b1; lr_ready = 1'b1;
      #1;
      chk("R8 oldest out", lr_data, 32'h2000_0000);
      step();
      cp_wr_en = 1'b0; lr_ready = 1'b0;
      status_is("R8 count stays 4", 32'h0000_0000);
      pop_expect("R8 order 1", 32'h2000_0001);
      pop_expect("R8 order 2", 32'h2000_0002);
      pop_expect("R8 order 3", 32'h2000_0003);
      pop_expect("R8 appended last", 32'h2000_0044);
      chk("R9 lr_valid low", {31'd0, lr_valid}, 32'd0);
      status_is("R10 all free", 32'h0000_0004);
   endtask

   initial begin
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_plain();
      t_irq();
      t_empty_read();
      t_inbound();
      t_concurrent();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule